// File: doc/BRIEF.md
# Debug Break Request Unit

This block sits beside a small CPU core during emulation. It watches the instruction fetch stream, the data-memory bus, stack accesses and a per-instruction snapshot of the register file, and turns any of nine break conditions into one break request with a cause code. The sources are:

- a host-forced break;
- an external break pin, filtered and edge-detected;
- a set of PC breakpoint slots;
- an ordered three-address PC sequence with a pass count;
- a masked data-access match;
- a masked register-value match;
- three access-violation checks: an undefined address, a write into a protected window, and a stack access outside its window.

The bus inputs are observation strobes (`fetch_vld`, `mem_vld`, `stk_vld`, `ins_done`). They are sampled whenever they are high, and the block never applies back-pressure. Nothing carries a ready signal, because the core cannot be stalled by this unit.

When a condition hits, the unit does the following:

- It raises `brk_req` for one cycle in the following cycle.
- It latches the cause code.
- It holds `brk_active` until the next emulation restart (`emu_start`).

While the core acknowledges an interrupt, any hit is held pending. The pending break is taken at the first fetch once the acknowledge drops, which is the first instruction of the handler. The stop status output `stop_n` is low while the core is halted or sleeping, and also while a break is in effect.

Top module: `dbg_break_unit`

## Requirements
- R1: A fetch (`fetch_vld`=1) whose PC equals the address of an enabled breakpoint slot (`cfg_bp_en[k]`=1, address in `cfg_bp_pc[k*PW +: PW]`) causes a break with cause 2. A disabled slot has no effect.
- R2: The sequence break fires with cause 3 only after three things happen in order: a fetch at `cfg_seq_pc1`, then a fetch at `cfg_seq_pc2`, then the `cfg_seq_cnt`-th fetch at `cfg_seq_pc3`. A count of 0 acts as 1. Fetches out of order do not advance the sequence, and the sequence returns to its start after it fires.
- R3: A data access (`mem_vld`=1) fires with cause 4 when all three of these hold:
  - the address is within `cfg_d_lo`..`cfg_d_hi` inclusive;
  - `(mem_data ^ cfg_d_val) & cfg_d_mask` is zero;
  - `(mem_wr ^ cfg_rw_val) & cfg_rw_mask` is zero.
  A mask bit of 1 means that bit is compared.
- R4: With `ins_done`=1, a break with cause 5 fires when `(reg_snap ^ cfg_r_val) & cfg_r_mask` is zero. The snapshot is packed as {A, B, flags E I C Z, X, Y}, with A in the most significant bits.
- R5: The three access violations, and the write suppression that goes with one of them:
  - Cause 6 fires on a fetch PC above `cfg_rom_top`, or on a data access outside both `cfg_ram_lo`..`cfg_ram_hi` and `cfg_io_lo`..`cfg_io_hi`.
  - Cause 7 fires on a data write inside `cfg_wp_lo`..`cfg_wp_hi`. While source 7 is enabled, such a write is removed from `mem_we_out`. Any other write passes through as `mem_vld & mem_wr`.
  - Cause 8 fires on a stack access outside `cfg_stk_lo`..`cfg_stk_hi`.
- R6: The external pin `ext_brk_n` is synchronised and must stay low for `FILT_LEN` consecutive samples before it fires a break with cause 1. A shorter low pulse is ignored.
- R7: A high on `host_brk` causes a break with cause 0.
- R8: When several enabled sources hit in the same cycle, the lowest cause number is reported. A pending cause merges with new hits in the same way.
- R9: A hit in cycle t raises `brk_req` for exactly one cycle at t+1 and sets `brk_active`. While `brk_active` is 1, further hits produce no request.
- R10: A hit while `intack`=1 produces no request in the next cycle. The break is held pending and taken at the first cycle with `intack`=0 and `fetch_vld`=1, or earlier if a new hit occurs with `intack`=0.
- R11: `stop_n` is 0 exactly when `halt_sleep`=1 or `brk_active`=1.
- R12: `emu_start` does three things: it clears `brk_active` and any pending break, it returns the PC sequence and its pass counter to the start, and it blocks any break in its own cycle.
- R13: Bit i of `cfg_src_en` enables source i, using the cause numbering above. A disabled source produces no break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| emu_start | input | 1 | Emulation restart pulse |
| host_brk | input | 1 | Host forced break |
| ext_brk_n | input | 1 | Asynchronous external break pin, active low |
| intack | input | 1 | Interrupt acknowledge in progress |
| halt_sleep | input | 1 | Core is halted or sleeping |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_pc | input | PW | Fetch address |
| mem_vld | input | 1 | Data access strobe |
| mem_addr | input | AW | Data address |
| mem_data | input | DW | Data value |
| mem_wr | input | 1 | 1 = write, 0 = read |
| mem_we_out | output | 1 | Write enable passed to memory, with protected writes removed |
| stk_vld | input | 1 | Stack access strobe |
| stk_addr | input | AW | Stack access address |
| ins_done | input | 1 | Instruction completed, snapshot valid |
| reg_snap | input | 2*ACCW+4+2*IDXW | Register snapshot {A,B,EICZ,X,Y} |
| cfg_src_en | input | 9 | Per-source enables indexed by cause |
| cfg_bp_en | input | NBP | Breakpoint slot enables |
| cfg_bp_pc | input | NBP*PW | Breakpoint slot addresses |
| cfg_seq_pc1 | input | PW | Sequence address 1 |
| cfg_seq_pc2 | input | PW | Sequence address 2 |
| cfg_seq_pc3 | input | PW | Sequence address 3 |
| cfg_seq_cnt | input | CW | Pass count for address 3 |
| cfg_d_lo | input | AW | Data break range low |
| cfg_d_hi | input | AW | Data break range high |
| cfg_d_val | input | DW | Data compare value |
| cfg_d_mask | input | DW | Data compare mask |
| cfg_rw_val | input | 1 | Direction compare value |
| cfg_rw_mask | input | 1 | Direction compare mask |
| cfg_r_val | input | 2*ACCW+4+2*IDXW | Register compare value |
| cfg_r_mask | input | 2*ACCW+4+2*IDXW | Register compare mask |
| cfg_rom_top | input | PW | Highest valid fetch address |
| cfg_ram_lo | input | AW | RAM window low |
| cfg_ram_hi | input | AW | RAM window high |
| cfg_io_lo | input | AW | I/O window low |
| cfg_io_hi | input | AW | I/O window high |
| cfg_wp_lo | input | AW | Write-protect window low |
| cfg_wp_hi | input | AW | Write-protect window high |
| cfg_stk_lo | input | AW | Stack window low |
| cfg_stk_hi | input | AW | Stack window high |
| brk_req | output | 1 | One-cycle break request |
| brk_cause | output | 4 | Latched cause code |
| brk_active | output | 1 | Break in effect |
| stop_n | output | 1 | Low while halted, sleeping or in break |

## Verification
The bench targets the following corner cases:

- **Sequence order and count.** It sends the sequence addresses out of order and interrupts the pass count with a restart. A sequencer that matched in any order, or kept its count across `emu_start`, would raise a cause-3 break early.
- **Coincident hits.** Several sources hit in the same cycle. A wrong priority encoder would report a higher cause.
- **Interrupt acknowledge.** Hits arrive during `intack`. A design without deferral would request a break inside the acknowledge, and one that never released the pending break would hang.
- **External pin.** A short low glitch on the pin must not cause a break.
- **Protected writes.** A write into the protected window must be removed from `mem_we_out`. If it leaked through, the protected memory would be corrupted.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NSRC    = 9;
  localparam int CAUSE_W = 4;

  localparam int SRC_HOST  = 0;
  localparam int SRC_PIN   = 1;
  localparam int SRC_PCBP  = 2;
  localparam int SRC_SEQ   = 3;
  localparam int SRC_DATA  = 4;
  localparam int SRC_REG   = 5;
  localparam int SRC_UNDEF = 6;
  localparam int SRC_WPROT = 7;
  localparam int SRC_STACK = 8;

  typedef enum logic [1:0] {
    SQ_WAIT1 = 2'd0,
    SQ_WAIT2 = 2'd1,
    SQ_COUNT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/brk_pin_filter.sv
module brk_pin_filter #(
  parameter int FILT_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall_pulse
);
  localparam int CNTW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic            sync_a, sync_b, level;
  logic [CNTW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a     <= 1'b1;
      sync_b     <= 1'b1;
      level      <= 1'b1;
      run_cnt    <= '0;
      fall_pulse <= 1'b0;
    end else begin
      sync_a     <= pin_n;
      sync_b     <= sync_a;
      fall_pulse <= 1'b0;
      if (sync_b != level) begin
        if (run_cnt == CNTW'(FILT_LEN - 1)) begin
          level      <= sync_b;
          run_cnt    <= '0;
          fall_pulse <= ~sync_b;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end else begin
        run_cnt <= '0;
      end
    end
  end

  // R6
  filt_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(level) |-> !$past(sync_b));
endmodule

// File: rtl/brk_seq_match.sv
module brk_seq_match import brk_pkg::*; #(
  parameter int PW = 13,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          fetch_vld,
  input  logic [PW-1:0] fetch_pc,
  input  logic [PW-1:0] pc1,
  input  logic [PW-1:0] pc2,
  input  logic [PW-1:0] pc3,
  input  logic [CW-1:0] pass_cnt,
  output logic          seq_hit
);
  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic [CW:0]   target;
  logic          reached;

  assign target  = (pass_cnt == '0) ? (CW+1)'(1) : {1'b0, pass_cnt};
  assign reached = ({1'b0, cnt} + (CW+1)'(1)) >= target;
  assign seq_hit = fetch_vld && (state == SQ_COUNT) && (fetch_pc == pc3) && reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_WAIT1;
      cnt   <= '0;
    end else if (restart) begin
      state <= SQ_WAIT1;
      cnt   <= '0;
    end else if (fetch_vld) begin
      unique case (state)
        SQ_WAIT1: if (fetch_pc == pc1) state <= SQ_WAIT2;
        SQ_WAIT2: if (fetch_pc == pc2) begin
          state <= SQ_COUNT;
          cnt   <= '0;
        end
        SQ_COUNT: if (fetch_pc == pc3) begin
          if (reached) begin
            state <= SQ_WAIT1;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SQ_WAIT1;
      endcase
    end
  end

  // R2
  seq_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_hit |=> state == SQ_WAIT1);
  // R12
  seq_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (state == SQ_WAIT1) && (cnt == '0));
endmodule

// File: rtl/brk_cond_match.sv
module brk_cond_match #(
  parameter int NBP = 4,
  parameter int PW  = 13,
  parameter int AW  = 12,
  parameter int DW  = 4,
  parameter int RW  = 44
) (
  input  logic              fetch_vld,
  input  logic [PW-1:0]     fetch_pc,
  input  logic              mem_vld,
  input  logic [AW-1:0]     mem_addr,
  input  logic [DW-1:0]     mem_data,
  input  logic              mem_wr,
  input  logic              stk_vld,
  input  logic [AW-1:0]     stk_addr,
  input  logic              ins_done,
  input  logic [RW-1:0]     reg_snap,
  input  logic [NBP-1:0]    bp_en,
  input  logic [NBP*PW-1:0] bp_pc,
  input  logic [AW-1:0]     d_lo,
  input  logic [AW-1:0]     d_hi,
  input  logic [DW-1:0]     d_val,
  input  logic [DW-1:0]     d_mask,
  input  logic              rw_val,
  input  logic              rw_mask,
  input  logic [RW-1:0]     r_val,
  input  logic [RW-1:0]     r_mask,
  input  logic [PW-1:0]     rom_top,
  input  logic [AW-1:0]     ram_lo,
  input  logic [AW-1:0]     ram_hi,
  input  logic [AW-1:0]     io_lo,
  input  logic [AW-1:0]     io_hi,
  input  logic [AW-1:0]     wp_lo,
  input  logic [AW-1:0]     wp_hi,
  input  logic [AW-1:0]     stk_lo,
  input  logic [AW-1:0]     stk_hi,
  output logic              pcbp_hit,
  output logic              data_hit,
  output logic              reg_hit,
  output logic              undef_hit,
  output logic              wprot_hit,
  output logic              stack_hit
);
  logic [NBP-1:0] slot_hit;

  for (genvar k = 0; k < NBP; k++) begin : g_slot
    assign slot_hit[k] = bp_en[k] && (fetch_pc == bp_pc[k*PW +: PW]);
  end

  logic in_drange, in_ram, in_io, in_wp, in_stk;
  assign in_drange = (mem_addr >= d_lo)   && (mem_addr <= d_hi);
  assign in_ram    = (mem_addr >= ram_lo) && (mem_addr <= ram_hi);
  assign in_io     = (mem_addr >= io_lo)  && (mem_addr <= io_hi);
  assign in_wp     = (mem_addr >= wp_lo)  && (mem_addr <= wp_hi);
  assign in_stk    = (stk_addr >= stk_lo) && (stk_addr <= stk_hi);

  assign pcbp_hit  = fetch_vld && (|slot_hit);
  assign data_hit  = mem_vld && in_drange &&
                     (((mem_data ^ d_val) & d_mask) == '0) &&
                     (((mem_wr ^ rw_val) & rw_mask) == 1'b0);
  assign reg_hit   = ins_done && (((reg_snap ^ r_val) & r_mask) == '0);
  assign undef_hit = (fetch_vld && (fetch_pc > rom_top)) ||
                     (mem_vld && !(in_ram || in_io));
  assign wprot_hit = mem_vld && mem_wr && in_wp;
  assign stack_hit = stk_vld && !in_stk;
endmodule

// File: rtl/dbg_break_unit.sv
module dbg_break_unit import brk_pkg::*; #(
  parameter int NBP      = 4,
  parameter int PW       = 13,
  parameter int AW       = 12,
  parameter int DW       = 4,
  parameter int ACCW     = 4,
  parameter int IDXW     = 16,
  parameter int CW       = 8,
  parameter int FILT_LEN = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         emu_start,
  input  logic                         host_brk,
  input  logic                         ext_brk_n,
  input  logic                         intack,
  input  logic                         halt_sleep,
  input  logic                         fetch_vld,
  input  logic [PW-1:0]                fetch_pc,
  input  logic                         mem_vld,
  input  logic [AW-1:0]                mem_addr,
  input  logic [DW-1:0]                mem_data,
  input  logic                         mem_wr,
  output logic                         mem_we_out,
  input  logic                         stk_vld,
  input  logic [AW-1:0]                stk_addr,
  input  logic                         ins_done,
  input  logic [2*ACCW+4+2*IDXW-1:0]   reg_snap,
  input  logic [8:0]                   cfg_src_en,
  input  logic [NBP-1:0]               cfg_bp_en,
  input  logic [NBP*PW-1:0]            cfg_bp_pc,
  input  logic [PW-1:0]                cfg_seq_pc1,
  input  logic [PW-1:0]                cfg_seq_pc2,
  input  logic [PW-1:0]                cfg_seq_pc3,
  input  logic [CW-1:0]                cfg_seq_cnt,
  input  logic [AW-1:0]                cfg_d_lo,
  input  logic [AW-1:0]                cfg_d_hi,
  input  logic [DW-1:0]                cfg_d_val,
  input  logic [DW-1:0]                cfg_d_mask,
  input  logic                         cfg_rw_val,
  input  logic                         cfg_rw_mask,
  input  logic [2*ACCW+4+2*IDXW-1:0]   cfg_r_val,
  input  logic [2*ACCW+4+2*IDXW-1:0]   cfg_r_mask,
  input  logic [PW-1:0]                cfg_rom_top,
  input  logic [AW-1:0]                cfg_ram_lo,
  input  logic [AW-1:0]                cfg_ram_hi,
  input  logic [AW-1:0]                cfg_io_lo,
  input  logic [AW-1:0]                cfg_io_hi,
  input  logic [AW-1:0]                cfg_wp_lo,
  input  logic [AW-1:0]                cfg_wp_hi,
  input  logic [AW-1:0]                cfg_stk_lo,
  input  logic [AW-1:0]                cfg_stk_hi,
  output logic                         brk_req,
  output logic [3:0]                   brk_cause,
  output logic                         brk_active,
  output logic                         stop_n
);
  localparam int RW = 2*ACCW + 4 + 2*IDXW;

  logic pin_fall, seq_hit;
  logic pcbp_hit, data_hit, reg_hit, undef_hit, wprot_hit, stack_hit;

  brk_pin_filter #(.FILT_LEN(FILT_LEN)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_brk_n), .fall_pulse(pin_fall)
  );

  brk_seq_match #(.PW(PW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(emu_start),
    .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
    .pc1(cfg_seq_pc1), .pc2(cfg_seq_pc2), .pc3(cfg_seq_pc3),
    .pass_cnt(cfg_seq_cnt), .seq_hit(seq_hit)
  );

  brk_cond_match #(.NBP(NBP), .PW(PW), .AW(AW), .DW(DW), .RW(RW)) u_cond (
    .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
    .mem_vld(mem_vld), .mem_addr(mem_addr), .mem_data(mem_data), .mem_wr(mem_wr),
    .stk_vld(stk_vld), .stk_addr(stk_addr),
    .ins_done(ins_done), .reg_snap(reg_snap),
    .bp_en(cfg_bp_en), .bp_pc(cfg_bp_pc),
    .d_lo(cfg_d_lo), .d_hi(cfg_d_hi), .d_val(cfg_d_val), .d_mask(cfg_d_mask),
    .rw_val(cfg_rw_val), .rw_mask(cfg_rw_mask),
    .r_val(cfg_r_val), .r_mask(cfg_r_mask),
    .rom_top(cfg_rom_top), .ram_lo(cfg_ram_lo), .ram_hi(cfg_ram_hi),
    .io_lo(cfg_io_lo), .io_hi(cfg_io_hi), .wp_lo(cfg_wp_lo), .wp_hi(cfg_wp_hi),
    .stk_lo(cfg_stk_lo), .stk_hi(cfg_stk_hi),
    .pcbp_hit(pcbp_hit), .data_hit(data_hit), .reg_hit(reg_hit),
    .undef_hit(undef_hit), .wprot_hit(wprot_hit), .stack_hit(stack_hit)
  );

  logic [NSRC-1:0]    raw_hits, hits;
  logic [CAUSE_W-1:0] cur_cause, take_cause, pend_cause;
  logic               any_hit, take, pend;

  assign raw_hits = {stack_hit, wprot_hit, undef_hit, reg_hit, data_hit,
                     seq_hit, pcbp_hit, pin_fall, host_brk};
  assign hits     = raw_hits & cfg_src_en;
  assign any_hit  = |hits;

  always_comb begin
    cur_cause = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (hits[i]) cur_cause = CAUSE_W'(i);
  end

  always_comb begin
    if (pend && !(any_hit && (cur_cause < pend_cause))) take_cause = pend_cause;
    else                                               take_cause = cur_cause;
  end

  assign take = !emu_start && !brk_active && !intack &&
                (any_hit || (pend && fetch_vld));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req    <= 1'b0;
      brk_cause  <= '0;
      brk_active <= 1'b0;
      pend       <= 1'b0;
      pend_cause <= '0;
    end else begin
      brk_req <= 1'b0;
      if (emu_start) begin
        brk_active <= 1'b0;
        pend       <= 1'b0;
      end else if (take) begin
        brk_req    <= 1'b1;
        brk_cause  <= take_cause;
        brk_active <= 1'b1;
        pend       <= 1'b0;
      end else if (!brk_active && intack && any_hit) begin
        pend       <= 1'b1;
        pend_cause <= take_cause;
      end
    end
  end

  assign mem_we_out = mem_vld && mem_wr && !(wprot_hit && cfg_src_en[SRC_WPROT]);
  assign stop_n     = !(halt_sleep || brk_active);

  // R10
  intack_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intack |=> !brk_req);
  // R9
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_active && !emu_start) |=> !brk_req);
  // R12
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emu_start |=> !brk_active);
  // R11
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !stop_n);
  // R8
  cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (brk_cause < CAUSE_W'(NSRC)));
endmodule

// File: tb/sim_dbg_break_unit.sv
`timescale 1ns/1ps
module sim_dbg_break_unit;
  localparam int NBP = 4, PW = 13, AW = 12, DW = 4, ACCW = 4, IDXW = 16, CW = 8, FILT = 16;
  localparam int RW = 2*ACCW + 4 + 2*IDXW;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic emu_start = 0, host_brk = 0, ext_brk_n = 1, intack = 0, halt_sleep = 0;
  logic fetch_vld = 0; logic [PW-1:0] fetch_pc = 0;
  logic mem_vld = 0; logic [AW-1:0] mem_addr = 0; logic [DW-1:0] mem_data = 0; logic mem_wr = 0;
  logic stk_vld = 0; logic [AW-1:0] stk_addr = 0;
  logic ins_done = 0; logic [RW-1:0] reg_snap = 0;
  logic [8:0] src_en; logic [NBP-1:0] bp_en; logic [NBP*PW-1:0] bp_pc;
  logic [PW-1:0] sp1, sp2, sp3, rom_top; logic [CW-1:0] scnt;
  logic [AW-1:0] d_lo, d_hi, ram_lo, ram_hi, io_lo, io_hi, wp_lo, wp_hi, st_lo, st_hi;
  logic [DW-1:0] d_val, d_mask; logic rw_val, rw_mask; logic [RW-1:0] r_val, r_mask;
  logic mem_we_out, brk_req, brk_active, stop_n; logic [3:0] brk_cause;

  dbg_break_unit #(.NBP(NBP), .PW(PW), .AW(AW), .DW(DW), .ACCW(ACCW), .IDXW(IDXW),
                   .CW(CW), .FILT_LEN(FILT)) u0 (
    .clk(clk), .rst_n(rst_n), .emu_start(emu_start), .host_brk(host_brk),
    .ext_brk_n(ext_brk_n), .intack(intack), .halt_sleep(halt_sleep),
    .fetch_vld(fetch_vld), .fetch_pc(fetch_pc), .mem_vld(mem_vld), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_wr(mem_wr), .mem_we_out(mem_we_out),
    .stk_vld(stk_vld), .stk_addr(stk_addr), .ins_done(ins_done), .reg_snap(reg_snap),
    .cfg_src_en(src_en), .cfg_bp_en(bp_en), .cfg_bp_pc(bp_pc),
    .cfg_seq_pc1(sp1), .cfg_seq_pc2(sp2), .cfg_seq_pc3(sp3), .cfg_seq_cnt(scnt),
    .cfg_d_lo(d_lo), .cfg_d_hi(d_hi), .cfg_d_val(d_val), .cfg_d_mask(d_mask),
    .cfg_rw_val(rw_val), .cfg_rw_mask(rw_mask), .cfg_r_val(r_val), .cfg_r_mask(r_mask),
    .cfg_rom_top(rom_top), .cfg_ram_lo(ram_lo), .cfg_ram_hi(ram_hi),
    .cfg_io_lo(io_lo), .cfg_io_hi(io_hi), .cfg_wp_lo(wp_lo), .cfg_wp_hi(wp_hi),
    .cfg_stk_lo(st_lo), .cfg_stk_hi(st_hi),
    .brk_req(brk_req), .brk_cause(brk_cause), .brk_active(brk_active), .stop_n(stop_n)
  );

  int checks = 0, errors = 0;
  bit chk_model = 1;

  // model state
  logic m_active = 0, m_pend = 0, m_req = 0;
  int   m_cause = 0, m_pcause = 0, m_st = 0, m_cnt = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [8:0] hits_f();
    logic [8:0] h = '0;
    int tgt = (scnt == 0) ? 1 : int'(scnt);
    h[0] = host_brk;
    for (int k = 0; k < NBP; k++)
      if (fetch_vld && bp_en[k] && fetch_pc == bp_pc[k*PW +: PW]) h[2] = 1;
    h[3] = fetch_vld && m_st == 2 && fetch_pc == sp3 && (m_cnt + 1 >= tgt);
    h[4] = mem_vld && mem_addr >= d_lo && mem_addr <= d_hi &&
           (((mem_data ^ d_val) & d_mask) == 0) && (((mem_wr ^ rw_val) & rw_mask) == 0);
    h[5] = ins_done && (((reg_snap ^ r_val) & r_mask) == 0);
    h[6] = (fetch_vld && fetch_pc > rom_top) ||
           (mem_vld && !((mem_addr >= ram_lo && mem_addr <= ram_hi) ||
                         (mem_addr >= io_lo && mem_addr <= io_hi)));
    h[7] = mem_vld && mem_wr && mem_addr >= wp_lo && mem_addr <= wp_hi;
    h[8] = stk_vld && (stk_addr < st_lo || stk_addr > st_hi);
    return h & src_en;
  endfunction

  function automatic int low_f(logic [8:0] h);
    for (int i = 0; i < 9; i++) if (h[i]) return i;
    return 15;
  endfunction

  task automatic tick();
    logic [8:0] h;
    int c, tgt;
    #1;
    h = hits_f();
    // R5 write suppression seen at the port before the edge
    if (chk_model) chk("R5 mem_we_out", mem_we_out, mem_vld && mem_wr && !h[7]);
    c = low_f(h);
    m_req = 0;
    if (emu_start) begin
      m_active = 0; m_pend = 0;
    end else if (!m_active) begin
      if (!intack && (h != 0 || (m_pend && fetch_vld))) begin
        m_req = 1; m_active = 1;
        m_cause = m_pend ? ((h != 0 && c < m_pcause) ? c : m_pcause) : c;
        m_pend = 0;
      end else if (intack && h != 0) begin
        m_pcause = m_pend ? ((c < m_pcause) ? c : m_pcause) : c;
        m_pend = 1;
      end
    end
    tgt = (scnt == 0) ? 1 : int'(scnt);
    if (emu_start) begin m_st = 0; m_cnt = 0; end
    else if (fetch_vld) begin
      if (m_st == 0 && fetch_pc == sp1) m_st = 1;
      else if (m_st == 1 && fetch_pc == sp2) begin m_st = 2; m_cnt = 0; end
      else if (m_st == 2 && fetch_pc == sp3) begin
        if (m_cnt + 1 >= tgt) begin m_st = 0; m_cnt = 0; end
        else m_cnt++;
      end
    end
    @(posedge clk); @(negedge clk);
    if (chk_model) begin
      chk("R9 brk_req", brk_req, m_req);
      chk("R9 brk_active", brk_active, m_active);
      chk("R11 stop_n", stop_n, !(halt_sleep || m_active));
      if (m_req) chk("R8 brk_cause", brk_cause, m_cause);
    end
  endtask

  task automatic idle();
    host_brk = 0; fetch_vld = 0; mem_vld = 0; mem_wr = 0; stk_vld = 0;
    ins_done = 0; intack = 0; emu_start = 0; halt_sleep = 0;
  endtask

  task automatic restart();
    idle(); emu_start = 1; tick(); emu_start = 0;
  endtask

  task automatic expect_brk(string tag, int req, int cause);
    chk(tag, brk_req, req);
    if (req) chk(tag, brk_cause, cause);
  endtask

  task automatic fetch(logic [PW-1:0] pc);
    idle(); fetch_vld = 1; fetch_pc = pc; tick();
  endtask

  task automatic rand_step();
    int r;
    fetch_vld = 1'($urandom % 2);
    r = $urandom % 10;
    case (r)
      0, 1, 2, 3: fetch_pc = bp_pc[r*PW +: PW];
      4: fetch_pc = sp1;
      5: fetch_pc = sp2;
      6: fetch_pc = sp3;
      7: fetch_pc = 13'h1900;
      default: fetch_pc = PW'($urandom % 32'h1800);
    endcase
    mem_vld = ($urandom % 4) == 0;
    r = $urandom % 8;
    mem_addr = (r == 0) ? AW'($urandom) : (r == 1) ? AW'(12'h100 + $urandom % 16) :
               (r == 2) ? AW'(12'h200 + $urandom % 128) : AW'($urandom % 12'h400);
    mem_data = DW'($urandom); mem_wr = 1'($urandom);
    stk_vld = ($urandom % 4) == 0;
    stk_addr = (($urandom % 6) == 0) ? AW'($urandom) : AW'(12'h300 + $urandom % 128);
    ins_done = 1'($urandom); reg_snap = {12'($urandom), $urandom};
    host_brk = ($urandom % 40) == 0;
    intack = ($urandom % 6) == 0;
    halt_sleep = ($urandom % 5) == 0;
    emu_start = m_active ? (($urandom % 3) == 0) : (($urandom % 50) == 0);
    if (emu_start) src_en = 9'($urandom) | 9'h004;
    tick();
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seen;
    void'($urandom(32'd20240611));
    src_en = 9'h1FF; bp_en = 4'b0111;
    bp_pc = {13'h0400, 13'h0300, 13'h0200, 13'h0100};
    sp1 = 13'h0010; sp2 = 13'h0020; sp3 = 13'h0030; scnt = 8'd3;
    rom_top = 13'h17FF;
    d_lo = 12'h100; d_hi = 12'h10F; d_val = 4'hA; d_mask = 4'hE; rw_val = 1; rw_mask = 1;
    ram_lo = 12'h000; ram_hi = 12'h3FF; io_lo = 12'hF00; io_hi = 12'hFFF;
    wp_lo = 12'h200; wp_hi = 12'h27F; st_lo = 12'h300; st_hi = 12'h37F;
    r_mask = {4'hF, {(RW-4){1'b0}}}; r_val = {4'h5, {(RW-4){1'b0}}};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset brk_req", brk_req, 0);
    chk("R9 reset brk_active", brk_active, 0);
    chk("R11 reset stop_n", stop_n, 1);
    chk("R8 reset brk_cause", brk_cause, 0);

    // R7 host forced break, then R9 hold while active
    idle(); host_brk = 1; tick(); expect_brk("R7 host", 1, 0);
    idle(); host_brk = 1; tick(); expect_brk("R9 no retrigger", 0, 0);
    chk("R11 stop low in break", stop_n, 0);
    restart();
    // R1 breakpoint slot and disabled slot
    fetch(13'h0200); expect_brk("R1 slot1", 1, 2); restart();
    fetch(13'h0400); expect_brk("R1 disabled slot", 0, 0);
    // R13 disabled source
    src_en = 9'h1FB; fetch(13'h0100); expect_brk("R13 source off", 0, 0); src_en = 9'h1FF;
    // R2 sequence: out-of-order then proper with count 3
    fetch(sp2); fetch(sp3); fetch(sp3); fetch(sp3); expect_brk("R2 out of order", 0, 0);
    fetch(sp1); fetch(sp2); fetch(sp3); fetch(13'h0055); fetch(sp3);
    expect_brk("R2 count not reached", 0, 0);
    fetch(sp3); expect_brk("R2 sequence", 1, 3); restart();
    // R12 restart clears sequence progress
    fetch(sp1); fetch(sp2); fetch(sp3); restart();
    fetch(sp3); fetch(sp3); fetch(sp3); expect_brk("R12 seq reset", 0, 0);
    // R3 data access
    idle(); mem_vld = 1; mem_addr = 12'h105; mem_data = 4'hB; mem_wr = 1; tick();
    expect_brk("R3 data match", 1, 4); restart();
    idle(); mem_vld = 1; mem_addr = 12'h105; mem_data = 4'h8; mem_wr = 1; tick();
    expect_brk("R3 data mismatch", 0, 0);
    idle(); mem_vld = 1; mem_addr = 12'h105; mem_data = 4'hA; mem_wr = 0; tick();
    expect_brk("R3 rw mismatch", 0, 0);
    // R4 register value
    idle(); ins_done = 1; reg_snap = {4'h5, 40'h12345_6789A}; tick();
    expect_brk("R4 reg match", 1, 5); restart();
    // R5 write protect, undefined, stack
    idle(); mem_vld = 1; mem_addr = 12'h210; mem_wr = 1; #1;
    chk("R5 write suppressed", mem_we_out, 0); tick();
    expect_brk("R5 write protect", 1, 7); restart();
    idle(); mem_vld = 1; mem_addr = 12'h050; mem_wr = 1; #1;
    chk("R5 write passes", mem_we_out, 1); tick(); expect_brk("R5 plain write", 0, 0);
    fetch(13'h1900); expect_brk("R5 undefined fetch", 1, 6); restart();
    idle(); mem_vld = 1; mem_addr = 12'h800; tick(); expect_brk("R5 undefined data", 1, 6); restart();
    idle(); stk_vld = 1; stk_addr = 12'h380; tick(); expect_brk("R5 stack", 1, 8); restart();
    // R8 priority
    idle(); host_brk = 1; stk_vld = 1; stk_addr = 12'h000; tick();
    expect_brk("R8 host over stack", 1, 0); restart();
    idle(); mem_vld = 1; mem_addr = 12'h10F; mem_data = 4'hA; mem_wr = 1;
    ins_done = 1; reg_snap = {4'h5, 40'h0}; tick();
    expect_brk("R8 data over reg", 1, 4); restart();
    // R10 deferral
    idle(); intack = 1; host_brk = 1; tick(); expect_brk("R10 held", 0, 0);
    idle(); tick(); expect_brk("R10 waits for fetch", 0, 0);
    fetch(13'h0050); expect_brk("R10 taken at handler", 1, 0); restart();
    // R11 halt
    idle(); halt_sleep = 1; tick(); chk("R11 halt low", stop_n, 0);
    idle(); tick(); chk("R11 running high", stop_n, 1);
    // R6 external pin
    chk_model = 0; idle();
    ext_brk_n = 0; repeat (5) tick(); ext_brk_n = 1;
    seen = 0; repeat (30) begin tick(); if (brk_req) seen++; end
    chk("R6 glitch ignored", seen, 0);
    ext_brk_n = 0; seen = 0;
    repeat (40) begin tick(); if (brk_req && brk_cause == 1) seen++; end
    chk("R6 long low", seen, 1);
    ext_brk_n = 1; repeat (40) tick();
    chk_model = 1; restart();
    // random phase
    for (int i = 0; i < 4000; i++) rand_step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule